// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits beside a direct-mapped, write-back primary cache. It keeps lines that the primary cache has just thrown out. When the primary cache misses, the same block address is offered to this buffer, and every stored tag is compared with it at once. On a match, the buffer hands back the stored line and the primary cache gives up its conflicting line in exchange. Each line keeps its own dirty state through the swap. On no match, the refill comes from memory, and the line the primary cache displaces is pushed into the buffer.

Each tag holds the whole block address, because an entry is not bound to any primary index. Each entry also carries a valid bit and a dirty bit. The buffer has four entries by default. Free entries are filled first. When every entry is in use, the oldest slot, tracked by a rotating pointer, is overwritten. If the overwritten line is modified, it leaves through a one-cycle writeback output; if it is clean, it is discarded. Pushing an address the buffer already holds refreshes that entry in place.

Top module: `vcache_top`

## Requirements
- R1: After reset every entry is empty: `lk_hit` is 0 for any address and `wb_valid` is 0.
- R2: Lookup is combinational. In the same cycle that `lk_valid` is high and `lk_baddr` equals the full block address of a valid entry, `lk_hit` is 1 and `lk_data`/`lk_dirty` show that entry. At most one entry matches any address.
- R3: `swap_go` in a cycle where `lk_hit` is 1 replaces the hit entry, at the next clock edge, with the displaced line (`disp_baddr`, `disp_data`, `disp_dirty`). The dirty bit of each line moves with it.
- R4: `swap_go` with a hit while `disp_valid` is 0 leaves the hit entry empty after the edge.
- R5: `swap_go` in a cycle with no hit changes nothing.
- R6: An insert of a new address takes the lowest-numbered empty entry. When no entry is empty, it overwrites the entry at the rotation pointer, and the pointer then advances by one, wrapping from ENTRIES-1 to 0. From reset this gives first-in first-out order.
- R7: When an insert overwrites a dirty entry, `wb_valid` is 1 for exactly the following cycle, with that entry's address and data. When it overwrites a clean entry, `wb_valid` stays 0.
- R8: An insert whose address is already held overwrites that entry's data and ORs in its dirty bit. It uses no second entry and evicts nothing.
- R9: An insert in the same cycle as a `swap_go` that hits is ignored.
- R10: When two addresses alternate in one primary slot, every access after the first is served by this buffer with the correct line data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_baddr | input | ADDR_W | Block address searched |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_data | output | DATA_W | Line data of the matching entry |
| lk_dirty | output | 1 | Dirty bit of the matching entry |
| swap_go | input | 1 | Commit exchange with the hit entry |
| disp_valid | input | 1 | Primary cache supplies a displaced line for the swap |
| disp_baddr | input | ADDR_W | Block address of the displaced line |
| disp_data | input | DATA_W | Data of the displaced line |
| disp_dirty | input | 1 | Dirty bit of the displaced line |
| ins_valid | input | 1 | Push an evicted primary line |
| ins_baddr | input | ADDR_W | Block address of the pushed line |
| ins_data | input | DATA_W | Data of the pushed line |
| ins_dirty | input | 1 | Dirty bit of the pushed line |
| wb_valid | output | 1 | Dirty line leaving the buffer (one cycle) |
| wb_baddr | output | ADDR_W | Address of the line written back |
| wb_data | output | DATA_W | Data of the line written back |

## Verification
The main exchange path is driven by two block addresses that alternate in one primary slot. This shows whether swaps really send the displaced line back in, and whether the data returned on each hit matches the line last swapped out. Filling past capacity with a dirty line first, and then with a clean line, separates oldest-first replacement from any other order and writeback from silent discard. Repeated pushes of one address, swaps without a displaced line, swaps on a miss, and a swap together with a push each test a single placement rule: an extra or missing entry shows up as a wrong hit or miss afterwards.

// File: rtl/vc_pkg.sv
package vc_pkg;
  parameter int unsigned VC_ENTRIES = 4;
  parameter int unsigned VC_ADDR_W  = 20;
  parameter int unsigned VC_DATA_W  = 32;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_match.sv
module vc_match #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 20,
  localparam int unsigned IW     = vc_pkg::idx_width(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
  input  logic [ADDR_W-1:0]              key,
  output logic [ENTRIES-1:0]             match,
  output logic                           any,
  output logic [IW-1:0]                  idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IW     = vc_pkg::idx_width(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [IW-1:0]      ptr,
  output logic [IW-1:0]      slot,
  output logic               full
);
  logic [IW-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IW'(i);
    end
  end

  assign full = &valid;
  assign slot = full ? ptr : free_idx;
endmodule

// File: rtl/vcache_top.sv
module vcache_top #(
  parameter int unsigned ENTRIES = vc_pkg::VC_ENTRIES,
  parameter int unsigned ADDR_W  = vc_pkg::VC_ADDR_W,
  parameter int unsigned DATA_W  = vc_pkg::VC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_baddr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_dirty,
  input  logic              swap_go,
  input  logic              disp_valid,
  input  logic [ADDR_W-1:0] disp_baddr,
  input  logic [DATA_W-1:0] disp_data,
  input  logic              disp_dirty,
  input  logic              ins_valid,
  input  logic [ADDR_W-1:0] ins_baddr,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              ins_dirty,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_baddr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int unsigned IW = vc_pkg::idx_width(ENTRIES);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [ENTRIES-1:0]             v_q, v_n;
  logic [ENTRIES-1:0]             d_q, d_n;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q, tag_n;
  logic [ENTRIES-1:0][DATA_W-1:0] dat_q, dat_n;
  logic [IW-1:0]                  ptr_q, ptr_n;
  logic                           wbv_q, wbv_n;
  logic [ADDR_W-1:0]              wba_q, wba_n;
  logic [DATA_W-1:0]              wbd_q, wbd_n;

  logic [ENTRIES-1:0] lk_match, ins_match;
  logic               lk_any, ins_any;
  logic [IW-1:0]      lk_idx, ins_idx, alloc_slot;
  logic               alloc_full;
  logic               swap_en, ins_en, upd_en;

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
    .valid(v_q), .tags(tag_q), .key(lk_baddr),
    .match(lk_match), .any(lk_any), .idx(lk_idx)
  );

  vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_ins_match (
    .valid(v_q), .tags(tag_q), .key(ins_baddr),
    .match(ins_match), .any(ins_any), .idx(ins_idx)
  );

  vc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .valid(v_q), .ptr(ptr_q), .slot(alloc_slot), .full(alloc_full)
  );

  assign lk_hit   = lk_valid && lk_any;
  assign lk_data  = dat_q[lk_idx];
  assign lk_dirty = d_q[lk_idx];

  // swap has priority; a concurrent insert is dropped
  assign swap_en = swap_go && lk_hit;
  assign ins_en  = ins_valid && !swap_en;
  assign upd_en  = swap_en || ins_en;

  always_comb begin
    v_n   = v_q;
    d_n   = d_q;
    tag_n = tag_q;
    dat_n = dat_q;
    ptr_n = ptr_q;
    wbv_n = 1'b0;
    wba_n = wba_q;
    wbd_n = wbd_q;
    if (swap_en) begin
      v_n[lk_idx]   = disp_valid;
      d_n[lk_idx]   = disp_valid && disp_dirty;
      tag_n[lk_idx] = disp_baddr;
      dat_n[lk_idx] = disp_data;
    end else if (ins_en) begin
      if (ins_any) begin
        dat_n[ins_idx] = ins_data;
        d_n[ins_idx]   = d_q[ins_idx] | ins_dirty;
      end else begin
        if (alloc_full) begin
          ptr_n = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
          if (d_q[alloc_slot]) begin
            wbv_n = 1'b1;
            wba_n = tag_q[alloc_slot];
            wbd_n = dat_q[alloc_slot];
          end
        end
        v_n[alloc_slot]   = 1'b1;
        d_n[alloc_slot]   = ins_dirty;
        tag_n[alloc_slot] = ins_baddr;
        dat_n[alloc_slot] = ins_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      d_q   <= '0;
      ptr_q <= '0;
      wbv_q <= 1'b0;
    end else begin
      wbv_q <= wbv_n;
      if (upd_en) begin
        v_q   <= v_n;
        d_q   <= d_n;
        ptr_q <= ptr_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q <= tag_n;
      dat_q <= dat_n;
    end
    if (wbv_n) begin
      wba_q <= wba_n;
      wbd_q <= wbd_n;
    end
  end

  assign wb_valid = wbv_q;
  assign wb_baddr = wba_q;
  assign wb_data  = wbd_q;
endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int unsigned ENTRIES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               swap_go,
  input logic               lk_hit,
  input logic               disp_valid,
  input logic               ins_valid,
  input logic               wb_valid,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec
);
  // R2: never two entries for one address
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R7, R9: a writeback only follows an accepted insert
  a_r7_wb_from_insert: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(ins_valid && !(swap_go && lk_hit)));

  // R3: a swap with a displaced line keeps the occupancy
  a_r3_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_go && lk_hit && disp_valid) |=> ($countones(valid_vec) == $past($countones(valid_vec))));

  // R4: a swap without a displaced line frees one entry
  a_r4_swap_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_go && lk_hit && !disp_valid) |=> ($countones(valid_vec) + 1 == $past($countones(valid_vec))));

  // R5: a swap on a miss with no insert leaves occupancy unchanged
  a_r5_miss_swap_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_go && !lk_hit && !ins_valid) |=> $stable(valid_vec));

  // R6: an accepted insert never lowers occupancy
  a_r6_insert_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !swap_go) |=> ($countones(valid_vec) >= $past($countones(valid_vec))));
endmodule

bind vcache_top vc_checker #(.ENTRIES(ENTRIES)) u_vc_checker (
  .clk(clk), .rst_n(rst_n), .swap_go(swap_go), .lk_hit(lk_hit),
  .disp_valid(disp_valid), .ins_valid(ins_valid), .wb_valid(wb_valid),
  .valid_vec(v_q), .match_vec(lk_match)
);

// File: tb/vcache_tb.sv
module vcache_top_tb_top;
  localparam int AW = 20;
  localparam int DW = 32;

  logic clk, rst_n;
  logic lk_valid, lk_hit, lk_dirty;
  logic [AW-1:0] lk_baddr;
  logic [DW-1:0] lk_data;
  logic swap_go, disp_valid, disp_dirty;
  logic [AW-1:0] disp_baddr;
  logic [DW-1:0] disp_data;
  logic ins_valid, ins_dirty;
  logic [AW-1:0] ins_baddr;
  logic [DW-1:0] ins_data;
  logic wb_valid;
  logic [AW-1:0] wb_baddr;
  logic [DW-1:0] wb_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  vcache_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_baddr(lk_baddr), .lk_hit(lk_hit),
    .lk_data(lk_data), .lk_dirty(lk_dirty),
    .swap_go(swap_go), .disp_valid(disp_valid), .disp_baddr(disp_baddr),
    .disp_data(disp_data), .disp_dirty(disp_dirty),
    .ins_valid(ins_valid), .ins_baddr(ins_baddr), .ins_data(ins_data),
    .ins_dirty(ins_dirty),
    .wb_valid(wb_valid), .wb_baddr(wb_baddr), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_baddr = '0; swap_go = 0; disp_valid = 0;
    disp_baddr = '0; disp_data = '0; disp_dirty = 0;
    ins_valid = 0; ins_baddr = '0; ins_data = '0; ins_dirty = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // push a line; returns wb state seen in the following cycle
  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic dy,
                      output logic wv, output logic [AW-1:0] wa, output logic [DW-1:0] wd);
    ins_valid = 1; ins_baddr = a; ins_data = d; ins_dirty = dy;
    @(negedge clk);
    ins_valid = 0;
    wv = wb_valid; wa = wb_baddr; wd = wb_data;
  endtask

  task automatic probe(input logic [AW-1:0] a, output logic h, output logic [DW-1:0] d,
                       output logic dy);
    lk_valid = 1; lk_baddr = a;
    #1;
    h = lk_hit; d = lk_data; dy = lk_dirty;
    lk_valid = 0;
  endtask

  task automatic t_reset();
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    probe(20'h00000, h, d, dy);
    chk("R1 hit after reset", h, 0);
    probe(20'h12345, h, d, dy);
    chk("R1 hit after reset", h, 0);
    chk("R1 wb after reset", wb_valid, 0);
  endtask

  task automatic t_conflict();
    logic [AW-1:0] pa; logic [DW-1:0] pd; logic pdy;
    logic wv; logic [AW-1:0] wa; logic [DW-1:0] wd;
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    pa = 20'h00100; pd = 32'hA000_0100; pdy = 0;
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] x;
      x = (k % 2 == 0) ? 20'h00500 : 20'h00100;
      lk_valid = 1; lk_baddr = x;
      #1;
      if (k == 0) begin
        chk("R10 first access misses", lk_hit, 0);
        lk_valid = 0;
        push(pa, pd, pdy, wv, wa, wd);
        pa = x; pd = {12'hA00, x}; pdy = 1;
      end else begin
        chk("R10 victim hit", lk_hit, 1);
        chk("R10 victim data", lk_data, {12'hA00, x});
        chk("R3 dirty travels", lk_dirty, (x == 20'h00100) ? (k > 2) : 1'b1);
        swap_go = 1; disp_valid = 1; disp_baddr = pa; disp_data = pd; disp_dirty = pdy;
        d = lk_data; dy = lk_dirty;
        @(negedge clk);
        idle();
        pa = x; pd = d; pdy = 1;
      end
    end
    probe(20'h00500, h, d, dy);
    chk("R3 swapped line present", h, 1);
  endtask

  task automatic t_fifo();
    logic wv; logic [AW-1:0] wa; logic [DW-1:0] wd;
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    for (int i = 0; i < 4; i++) begin
      push(AW'(20'h01000 + i), DW'(32'hB000_0000 + i), (i == 0), wv, wa, wd);
      chk("R6 no eviction while free", wv, 0);
    end
    push(20'h01004, 32'hB000_0004, 0, wv, wa, wd);
    chk("R7 dirty evict wb", wv, 1);
    chk("R7 wb address", wa, 20'h01000);
    chk("R7 wb data", wd, 32'hB000_0000);
    @(negedge clk);
    chk("R7 wb lasts one cycle", wb_valid, 0);
    probe(20'h01000, h, d, dy);
    chk("R6 oldest evicted", h, 0);
    push(20'h01005, 32'hB000_0005, 0, wv, wa, wd);
    chk("R7 clean evict silent", wv, 0);
    probe(20'h01001, h, d, dy);
    chk("R6 second oldest evicted", h, 0);
    probe(20'h01002, h, d, dy);
    chk("R6 younger kept", h, 1);
  endtask

  task automatic t_dup();
    logic wv; logic [AW-1:0] wa; logic [DW-1:0] wd;
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    push(20'h02000, 32'hC000_0001, 1, wv, wa, wd);
    push(20'h02000, 32'hC000_0002, 0, wv, wa, wd);
    probe(20'h02000, h, d, dy);
    chk("R8 updated data", d, 32'hC000_0002);
    chk("R8 dirty kept", dy, 1);
    for (int i = 1; i < 4; i++) begin
      push(AW'(20'h02000 + i), DW'(i), 0, wv, wa, wd);
      chk("R8 no eviction from duplicate", wv, 0);
    end
    probe(20'h02001, h, d, dy);
    chk("R8 neighbours held", h, 1);
    push(20'h02009, 32'h9, 0, wv, wa, wd);
    chk("R8 single copy evicted dirty", wv, 1);
    chk("R8 evicted data", wd, 32'hC000_0002);
  endtask

  task automatic t_swap_empty();
    logic wv; logic [AW-1:0] wa; logic [DW-1:0] wd;
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    push(20'h03000, 32'hD000_0000, 1, wv, wa, wd);
    lk_valid = 1; lk_baddr = 20'h03000; swap_go = 1; disp_valid = 0;
    #1;
    chk("R4 swap data out", lk_data, 32'hD000_0000);
    @(negedge clk);
    idle();
    probe(20'h03000, h, d, dy);
    chk("R4 entry freed", h, 0);
    for (int i = 1; i < 5; i++) begin
      push(AW'(20'h03000 + i), DW'(i), 0, wv, wa, wd);
      chk("R4 freed slot reused", wv, 0);
    end
  endtask

  task automatic t_swap_miss();
    logic wv; logic [AW-1:0] wa; logic [DW-1:0] wd;
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    push(20'h04000, 32'hE000_0000, 0, wv, wa, wd);
    lk_valid = 1; lk_baddr = 20'h04444; swap_go = 1; disp_valid = 1;
    disp_baddr = 20'h04555; disp_data = 32'h5; disp_dirty = 1;
    #1;
    chk("R5 miss reported", lk_hit, 0);
    @(negedge clk);
    idle();
    probe(20'h04555, h, d, dy);
    chk("R5 nothing written", h, 0);
    probe(20'h04000, h, d, dy);
    chk("R5 entry intact", h, 1);
  endtask

  task automatic t_swap_vs_ins();
    logic wv; logic [AW-1:0] wa; logic [DW-1:0] wd;
    logic h, dy; logic [DW-1:0] d;
    do_reset();
    push(20'h05000, 32'hF000_0000, 0, wv, wa, wd);
    lk_valid = 1; lk_baddr = 20'h05000; swap_go = 1; disp_valid = 1;
    disp_baddr = 20'h05111; disp_data = 32'hF111; disp_dirty = 1;
    ins_valid = 1; ins_baddr = 20'h05222; ins_data = 32'hF222; ins_dirty = 0;
    @(negedge clk);
    idle();
    probe(20'h05222, h, d, dy);
    chk("R9 insert ignored", h, 0);
    probe(20'h05111, h, d, dy);
    chk("R3 displaced line stored", h, 1);
    chk("R3 displaced data", d, 32'hF111);
    chk("R3 displaced dirty", dy, 1);
    probe(20'h05000, h, d, dy);
    chk("R3 swapped-out line gone", h, 0);
  endtask

  initial begin
    t_reset();
    t_conflict();
    t_fifo();
    t_dup();
    t_swap_empty();
    t_swap_miss();
    t_swap_vs_ins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule